// File: doc/BRIEF.md
# Two-Class Job Ring Scheduler

This block chooses the next job for a single processing engine from sixteen descriptor rings. Rings 0 to 7 form the urgent class and rings 8 to 15 the background class. Any ring may belong to a different bus master. A host tells the scheduler about new work by writing a ring's producer index through a small register port. The scheduler keeps the consumer index for each ring itself. A ring holds work when its producer and consumer indices differ and its enable bit is set.

While the engine is idle, the scheduler picks a ring. The urgent class always wins over the background class, and inside each class the rings take turns. The scheduler presents the ring number, the descriptor slot (the ring's consumer index) and a task tag, and holds them until the engine pulses done. The task tag is a running serial number. On done, the scheduler moves the consumer index forward, wrapping at the programmed ring size. It then reports the finished ring and its tag, sets a sticky per-ring status bit that the host can poll, and drives an interrupt level from the status bits whose interrupt enable is set. For rings chosen by a separate mask, it also sends a one-cycle doorbell request toward an external host.

Top module: `jobring_sched`

## Requirements
- R1: After reset, job_valid, cmp_valid, db_valid and irq are 0, every index and enable mask is 0, and the ring size register reads 16.
- R2: A ring is granted only while its enable bit (control word 0x20, bit n for ring n) is set and its producer index differs from its consumer index.
- R3: When any urgent ring (0 to 7) holds work at a grant, the grant goes to an urgent ring, never to a background ring (8 to 15).
- R4: Within a class, the search starts at the ring after the one granted last in that class, wraps around, and takes the first ring that holds work. After reset the search starts at the class's lowest ring.
- R5: Only one job is outstanding. job_valid stays high with ring, slot and tag unchanged until job_done, and it is low in the cycle after job_done.
- R6: On job_done the consumer index of the job's ring increments. When the incremented value equals the ring size (control word 0x23), it becomes 0.
- R7: Task tags start at 0 and increase by one per grant. The cycle after job_done, cmp_valid pulses with the ring and tag of the finished job.
- R8: Completion sets status bit n (control word 0x24). Writing 1 to a status bit clears it. irq is high while any status bit is set whose bit in the interrupt mask (0x21) is set.
- R9: db_valid pulses together with cmp_valid, with db_ring equal to the finished ring, only when that ring's bit in the doorbell mask (0x22) is set.
- R10: Register read data appears one cycle after the address. Address 0x00+n holds producer n, 0x10+n holds consumer n, and 0x20 to 0x24 hold the control words.
- R11: A job_done pulse while no job is outstanding has no effect on the completion outputs or on any index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address for a write, and read address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| job_valid | output | 1 | A job is outstanding at the engine |
| job_ring | output | 4 | Ring of the outstanding job |
| job_slot | output | 4 | Descriptor slot (consumer index) of the job |
| job_task | output | 8 | Task tag of the job |
| job_done | input | 1 | One-cycle completion pulse from the engine |
| cmp_valid | output | 1 | One-cycle completion report |
| cmp_ring | output | 4 | Ring of the completed job |
| cmp_task | output | 8 | Task tag of the completed job |
| irq | output | 1 | Interrupt level |
| db_valid | output | 1 | One-cycle doorbell request |
| db_ring | output | 4 | Ring that raised the doorbell |

## Verification
The assertions take for granted that job_done is a single-cycle pulse. They also assume the host writes only producer indices below the programmed ring size, and changes the ring size only when no ring's index would fall outside it. The stimulus keeps to these rules in four ways. It raises done for exactly one cycle per job. It shrinks the ring size only after every ring has drained to indices 0 or 1. It programs work with all enables off and then enables the rings in one write, so the grant order depends only on the arbitration rules. Finally, it pulses done once while idle to show that the pulse is ignored.

// File: rtl/jobring_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the job ring scheduler: scheduler states and the
// register address layout (page in bits 5:4, ring or word in bits 3:0).
package jobring_pkg;

    typedef enum logic {
        SCHED_IDLE = 1'b0,
        SCHED_BUSY = 1'b1
    } sched_state_e;

    localparam int REG_AW = 6;

    localparam logic [1:0] PAGE_PROD = 2'd0;
    localparam logic [1:0] PAGE_CONS = 2'd1;
    localparam logic [1:0] PAGE_CTRL = 2'd2;

    localparam logic [3:0] CTRL_EN    = 4'h0;
    localparam logic [3:0] CTRL_IRQEN = 4'h1;
    localparam logic [3:0] CTRL_DBEN  = 4'h2;
    localparam logic [3:0] CTRL_SIZE  = 4'h3;
    localparam logic [3:0] CTRL_STAT  = 4'h4;

endpackage

// File: rtl/jobring_regs.sv
`timescale 1ns/1ps
// Host-visible register file: producer indices, enable masks, ring size and
// sticky completion status with write-one-to-clear.
// Assumes NUM_RINGS is a power of two of at most 16 and DATA_W >= NUM_RINGS,
// DATA_W > IDX_W. Read data is registered (one cycle latency).
module jobring_regs
    import jobring_pkg::*;
#(
    parameter int NUM_RINGS = 16,
    parameter int IDX_W     = 4,
    parameter int DATA_W    = 16,
    localparam int RING_W   = $clog2(NUM_RINGS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_wr,
    input  logic [REG_AW-1:0]                 reg_addr,
    input  logic [DATA_W-1:0]                 reg_wdata,
    output logic [DATA_W-1:0]                 reg_rdata,
    input  logic [NUM_RINGS-1:0][IDX_W-1:0]   cons_idx,
    input  logic                              cmp_set,
    input  logic [RING_W-1:0]                 cmp_ring,
    output logic [NUM_RINGS-1:0][IDX_W-1:0]   prod_idx,
    output logic [NUM_RINGS-1:0]              ring_en,
    output logic [NUM_RINGS-1:0]              db_en,
    output logic [IDX_W:0]                    ring_size,
    output logic                              irq
);

    logic [1:0]            page;
    logic [3:0]            word;
    logic [RING_W-1:0]     sel_ring;
    logic                  ctrl_wr;
    logic [NUM_RINGS-1:0]  irq_en_q;
    logic [NUM_RINGS-1:0]  stat_q;
    logic [NUM_RINGS-1:0]  stat_set;
    logic [NUM_RINGS-1:0]  stat_clr;
    logic [DATA_W-1:0]     rd_next;

    assign page     = reg_addr[5:4];
    assign word     = reg_addr[3:0];
    assign sel_ring = reg_addr[RING_W-1:0];
    assign ctrl_wr  = reg_wr && (page == PAGE_CTRL);

    // Producer index storage, written by the host one ring at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_idx <= '0;
        end else if (reg_wr && (page == PAGE_PROD)) begin
            prod_idx[sel_ring] <= reg_wdata[IDX_W-1:0];
        end
    end

    // Control masks and ring size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_en   <= '0;
            irq_en_q  <= '0;
            db_en     <= '0;
            ring_size <= (IDX_W+1)'(1) << IDX_W;
        end else if (ctrl_wr) begin
            case (word)
                CTRL_EN:    ring_en   <= reg_wdata[NUM_RINGS-1:0];
                CTRL_IRQEN: irq_en_q  <= reg_wdata[NUM_RINGS-1:0];
                CTRL_DBEN:  db_en     <= reg_wdata[NUM_RINGS-1:0];
                CTRL_SIZE:  ring_size <= reg_wdata[IDX_W:0];
                default:    ;
            endcase
        end
    end

    // Set and clear terms for the sticky status bits.
    always_comb begin
        stat_set = '0;
        if (cmp_set) stat_set[cmp_ring] = 1'b1;
        stat_clr = (ctrl_wr && (word == CTRL_STAT)) ? reg_wdata[NUM_RINGS-1:0] : '0;
    end

    // Sticky completion status; a new completion wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~stat_clr) | stat_set;
    end

    assign irq = |(stat_q & irq_en_q);

    // Read multiplexer for the registered read port.
    always_comb begin
        rd_next = '0;
        case (page)
            PAGE_PROD: rd_next[IDX_W-1:0] = prod_idx[sel_ring];
            PAGE_CONS: rd_next[IDX_W-1:0] = cons_idx[sel_ring];
            PAGE_CTRL: begin
                case (word)
                    CTRL_EN:    rd_next[NUM_RINGS-1:0] = ring_en;
                    CTRL_IRQEN: rd_next[NUM_RINGS-1:0] = irq_en_q;
                    CTRL_DBEN:  rd_next[NUM_RINGS-1:0] = db_en;
                    CTRL_SIZE:  rd_next[IDX_W:0]       = ring_size;
                    CTRL_STAT:  rd_next[NUM_RINGS-1:0] = stat_q;
                    default:    rd_next = '0;
                endcase
            end
            default: rd_next = '0;
        endcase
    end

    // Register the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) reg_rdata <= '0;
        else        reg_rdata <= rd_next;
    end

endmodule

// File: rtl/jobring_cons.sv
`timescale 1ns/1ps
// Consumer index bank: one index per ring, advanced by one on each finished
// job of that ring and wrapped to zero at the programmed ring size.
// Assumes every index is below ring_size when it is advanced.
module jobring_cons #(
    parameter int NUM_RINGS = 16,
    parameter int IDX_W     = 4,
    localparam int RING_W   = $clog2(NUM_RINGS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            adv,
    input  logic [RING_W-1:0]               adv_ring,
    input  logic [IDX_W:0]                  ring_size,
    output logic [NUM_RINGS-1:0][IDX_W-1:0] cons_idx
);

    for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
        logic [IDX_W-1:0] idx_q;
        logic [IDX_W:0]   idx_inc;

        assign idx_inc     = {1'b0, idx_q} + (IDX_W+1)'(1);
        assign cons_idx[r] = idx_q;

        // Advance this ring's index on its own completions, with wrap.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                idx_q <= '0;
            end else if (adv && (adv_ring == RING_W'(r))) begin
                idx_q <= (idx_inc == ring_size) ? '0 : idx_inc[IDX_W-1:0];
            end
        end
    end

endmodule

// File: rtl/jobring_rr.sv
`timescale 1ns/1ps
// Round-robin picker for one class of rings. The search begins at the ring
// after the last one taken. Assumes N >= 2. 'take' marks an accepted grant.
module jobring_rr #(
    parameter int N       = 8,
    localparam int IW     = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          take,
    output logic          any,
    output logic [IW-1:0] pick
);

    logic [IW-1:0] last_q;

    // Rotating search for the first requester after the last grant.
    always_comb begin
        any  = 1'b0;
        pick = last_q;
        for (int k = 1; k <= N; k++) begin
            if (!any && req[(int'(last_q) + k) % N]) begin
                any  = 1'b1;
                pick = IW'((int'(last_q) + k) % N);
            end
        end
    end

    // Remember the last granted ring; reset points at the top ring so ring 0 goes first.
    always_ff @(posedge clk) begin
        if (!rst_n)    last_q <= IW'(N - 1);
        else if (take) last_q <= pick;
    end

endmodule

// File: rtl/jobring_sched.sv
`timescale 1ns/1ps
// Job ring scheduler for one processing engine. Rings below CLASS_RINGS are
// urgent, the rest background. Strict priority between classes, round robin
// inside each. One job outstanding at a time; job_done must be a one-cycle pulse.
// Assumes CLASS_RINGS is a power of two between 2 and 8.
module jobring_sched
    import jobring_pkg::*;
#(
    parameter int CLASS_RINGS = 8,
    parameter int IDX_W       = 4,
    parameter int TASK_W      = 8,
    parameter int DATA_W      = 16,
    localparam int NUM_RINGS  = 2 * CLASS_RINGS,
    localparam int RING_W     = $clog2(NUM_RINGS),
    localparam int PICK_W     = $clog2(CLASS_RINGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              job_valid,
    output logic [RING_W-1:0] job_ring,
    output logic [IDX_W-1:0]  job_slot,
    output logic [TASK_W-1:0] job_task,
    input  logic              job_done,
    output logic              cmp_valid,
    output logic [RING_W-1:0] cmp_ring,
    output logic [TASK_W-1:0] cmp_task,
    output logic              irq,
    output logic              db_valid,
    output logic [RING_W-1:0] db_ring
);

    logic [NUM_RINGS-1:0][IDX_W-1:0] prod_idx;
    logic [NUM_RINGS-1:0][IDX_W-1:0] cons_idx;
    logic [NUM_RINGS-1:0]            ring_en;
    logic [NUM_RINGS-1:0]            db_en;
    logic [IDX_W:0]                  ring_size;
    logic [NUM_RINGS-1:0]            pending;
    logic [1:0][CLASS_RINGS-1:0]     class_req;
    logic [1:0]                      class_any;
    logic [1:0][PICK_W-1:0]          class_pick;
    logic [1:0]                      class_take;

    sched_state_e      state_q;
    logic              grant;
    logic              win_lo;
    logic [RING_W-1:0] win_ring;
    logic              finish;
    logic [RING_W-1:0] cur_ring;
    logic [IDX_W-1:0]  cur_slot;
    logic [TASK_W-1:0] cur_task;
    logic [TASK_W-1:0] serial_q;

    jobring_regs #(
        .NUM_RINGS (NUM_RINGS),
        .IDX_W     (IDX_W),
        .DATA_W    (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cons_idx  (cons_idx),
        .cmp_set   (finish),
        .cmp_ring  (cur_ring),
        .prod_idx  (prod_idx),
        .ring_en   (ring_en),
        .db_en     (db_en),
        .ring_size (ring_size),
        .irq       (irq)
    );

    jobring_cons #(
        .NUM_RINGS (NUM_RINGS),
        .IDX_W     (IDX_W)
    ) u_cons (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (finish),
        .adv_ring  (cur_ring),
        .ring_size (ring_size),
        .cons_idx  (cons_idx)
    );

    // A ring holds work when enabled and its indices differ.
    for (genvar r = 0; r < NUM_RINGS; r++) begin : g_pend
        assign pending[r] = ring_en[r] && (prod_idx[r] != cons_idx[r]);
    end

    // One round-robin picker per priority class; class 0 is urgent.
    for (genvar c = 0; c < 2; c++) begin : g_class
        assign class_req[c]  = pending[c*CLASS_RINGS +: CLASS_RINGS];
        assign class_take[c] = grant && ((c == 0) ? class_any[0] : !class_any[0]);

        jobring_rr #(
            .N (CLASS_RINGS)
        ) u_rr (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (class_req[c]),
            .take  (class_take[c]),
            .any   (class_any[c]),
            .pick  (class_pick[c])
        );
    end

    assign grant    = (state_q == SCHED_IDLE) && (|class_any);
    assign win_lo   = !class_any[0];
    assign win_ring = {win_lo, class_pick[win_lo]};
    assign finish   = (state_q == SCHED_BUSY) && job_done;

    // Job issue and retirement sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SCHED_IDLE;
            cur_ring <= '0;
            cur_slot <= '0;
            cur_task <= '0;
            serial_q <= '0;
        end else if (grant) begin
            state_q  <= SCHED_BUSY;
            cur_ring <= win_ring;
            cur_slot <= cons_idx[win_ring];
            cur_task <= serial_q;
            serial_q <= serial_q + TASK_W'(1);
        end else if (finish) begin
            state_q  <= SCHED_IDLE;
        end
    end

    // Completion and doorbell reports, one cycle after done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_valid <= 1'b0;
            cmp_ring  <= '0;
            cmp_task  <= '0;
            db_valid  <= 1'b0;
            db_ring   <= '0;
        end else begin
            cmp_valid <= finish;
            db_valid  <= finish && db_en[cur_ring];
            if (finish) begin
                cmp_ring <= cur_ring;
                cmp_task <= cur_task;
                db_ring  <= cur_ring;
            end
        end
    end

    assign job_valid = (state_q == SCHED_BUSY);
    assign job_ring  = cur_ring;
    assign job_slot  = cur_slot;
    assign job_task  = cur_task;

    AST_JOB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        job_valid && !job_done |=> job_valid && $stable(job_ring) && $stable(job_slot) && $stable(job_task)); // R5

    AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(job_valid) |-> (($past(ring_en) >> job_ring) & NUM_RINGS'(1)) != '0); // R2

    AST_URGENT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(job_valid) && job_ring[RING_W-1] |-> $past(class_req[0]) == '0); // R3

    AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        job_done && !job_valid |=> !cmp_valid); // R11

    AST_DOORBELL_WITH_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        db_valid |-> cmp_valid && (db_ring == cmp_ring)); // R9

    AST_CMP_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> $past(job_valid && job_done)); // R7

endmodule

// File: tb/jobring_sched_tb.sv
`timescale 1ns/1ps
// Directed bench for the job ring scheduler: one task per scenario.
module jobring_sched_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        job_valid;
    logic [3:0]  job_ring;
    logic [3:0]  job_slot;
    logic [7:0]  job_task;
    logic        job_done = 1'b0;
    logic        cmp_valid;
    logic [3:0]  cmp_ring;
    logic [7:0]  cmp_task;
    logic        irq;
    logic        db_valid;
    logic [3:0]  db_ring;

    int checks = 0;
    int errors = 0;
    int exp_task = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    jobring_sched dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .job_valid (job_valid),
        .job_ring  (job_ring),
        .job_slot  (job_slot),
        .job_task  (job_task),
        .job_done  (job_done),
        .cmp_valid (cmp_valid),
        .cmp_ring  (cmp_ring),
        .cmp_task  (cmp_task),
        .irq       (irq),
        .db_valid  (db_valid),
        .db_ring   (db_ring)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        @(negedge clk);
        v = int'(reg_rdata);
    endtask

    // Wait for a grant, check it, hold it, finish it and check the report.
    task automatic run_job(input string req, input int ring, input int slot,
                           input int hold, input bit exp_db);
        int seen = 0;
        for (int i = 0; i < 20; i++) begin
            if (job_valid) begin seen = 1; break; end
            @(negedge clk);
        end
        chk(req, "job granted", seen, 1);
        chk(req, "job_ring", int'(job_ring), ring);
        chk(req, "job_slot", int'(job_slot), slot);
        chk("R7", "job_task", int'(job_task), exp_task);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk("R5", "held valid", int'(job_valid), 1);
            chk("R5", "held ring", int'(job_ring), ring);
        end
        job_done = 1'b1;
        @(negedge clk);
        job_done = 1'b0;
        chk("R5", "valid drops after done", int'(job_valid), 0);
        chk("R7", "cmp_valid", int'(cmp_valid), 1);
        chk("R7", "cmp_ring", int'(cmp_ring), ring);
        chk("R7", "cmp_task", int'(cmp_task), exp_task);
        chk("R9", "db_valid", int'(db_valid), int'(exp_db));
        if (exp_db) chk("R9", "db_ring", int'(db_ring), ring);
        exp_task++;
    endtask

    task automatic t_reset();
        int v;
        chk("R1", "job_valid", int'(job_valid), 0);
        chk("R1", "cmp_valid", int'(cmp_valid), 0);
        chk("R1", "db_valid", int'(db_valid), 0);
        chk("R1", "irq", int'(irq), 0);
        rd(6'h23, v); chk("R1", "ring size", v, 16);
        rd(6'h20, v); chk("R1", "enable mask", v, 0);
        rd(6'h17, v); chk("R1", "consumer 7", v, 0);
    endtask

    task automatic t_enable_and_status();
        int v;
        wr(6'h00, 16'd1);
        repeat (6) @(negedge clk);
        chk("R2", "disabled ring not granted", int'(job_valid), 0);
        wr(6'h20, 16'h0001);
        run_job("R2", 0, 0, 0, 1'b0);
        rd(6'h10, v); chk("R6", "consumer 0 advanced", v, 1);
        chk("R8", "irq masked", int'(irq), 0);
        rd(6'h24, v); chk("R8", "status bit 0", v, 1);
        wr(6'h21, 16'h0001);
        chk("R8", "irq enabled", int'(irq), 1);
        wr(6'h24, 16'h0001);
        chk("R8", "irq after clear", int'(irq), 0);
        rd(6'h24, v); chk("R8", "status cleared", v, 0);
    endtask

    task automatic t_priority();
        wr(6'h20, 16'h0000);
        wr(6'h09, 16'd1);
        wr(6'h03, 16'd1);
        wr(6'h20, 16'hFFFF);
        run_job("R3", 3, 0, 0, 1'b0);
        run_job("R3", 9, 0, 0, 1'b0);
    endtask

    task automatic t_round_robin();
        wr(6'h20, 16'h0000);
        wr(6'h01, 16'd1);
        wr(6'h04, 16'd1);
        wr(6'h06, 16'd1);
        wr(6'h20, 16'hFFFF);
        run_job("R4", 4, 0, 5, 1'b0);
        run_job("R4", 6, 0, 0, 1'b0);
        run_job("R4", 1, 0, 0, 1'b0);
    endtask

    task automatic t_wrap();
        int v;
        wr(6'h23, 16'd2);
        rd(6'h23, v); chk("R10", "size readback", v, 2);
        wr(6'h05, 16'd1);
        rd(6'h05, v); chk("R10", "producer 5 readback", v, 1);
        run_job("R6", 5, 0, 0, 1'b0);
        wr(6'h05, 16'd0);
        run_job("R6", 5, 1, 0, 1'b0);
        rd(6'h15, v); chk("R6", "consumer 5 wrapped", v, 0);
    endtask

    task automatic t_doorbell();
        wr(6'h22, 16'h0020);
        wr(6'h05, 16'd1);
        run_job("R9", 5, 0, 0, 1'b1);
        wr(6'h0A, 16'd1);
        run_job("R9", 10, 0, 0, 1'b0);
    endtask

    task automatic t_idle_done();
        int v;
        @(negedge clk);
        chk("R11", "idle before pulse", int'(job_valid), 0);
        job_done = 1'b1;
        @(negedge clk);
        job_done = 1'b0;
        chk("R11", "no completion", int'(cmp_valid), 0);
        chk("R11", "no doorbell", int'(db_valid), 0);
        rd(6'h1A, v); chk("R11", "consumer 10 unchanged", v, 1);
        rd(6'h15, v); chk("R11", "consumer 5 unchanged", v, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_and_status();
        t_priority();
        t_round_robin();
        t_wrap();
        t_doorbell();
        t_idle_done();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule